// File: doc/BRIEF.md
# Clustered Dispatch Steering Unit

This unit decides, for every instruction in a dispatch group of up to eight, which execution cluster of a clustered simultaneous-multithreading core receives it. Each instruction carries the hardware thread it belongs to. The unit also receives a count of free queue slots for every cluster. It returns a cluster index for each lane and the number of leading lanes it accepted. Lanes that are not accepted are dispatched again in a later cycle by the surrounding front end.

Two steering policies are available, selected each cycle.

- **Interleaved:** each thread sends runs of four instructions to one cluster, then rotates to the next cluster.
- **Bound:** each thread is confined to its own subset of clusters, and rotates in runs of four inside that subset.

Per-thread rotation state persists across cycles and is shared by both policies.

A companion timer models result visibility. When a value is produced in one cluster, it is ready there immediately. It becomes ready in every other cluster a programmable number of cycles later. An instruction may only be treated as commit-eligible once the value is ready everywhere.

Top module: `cluster_steer`

## Requirements
- R1: After reset every thread's rotation pointer is cluster 0 with an empty run, `bc_ready` is all zero and `bc_done` is low.
- R2: With `mode`=0 (interleaved), a thread's accepted instructions go to its current cluster. After four accepted instructions the thread moves to cluster (current+1) mod NC. The position persists across groups.
- R3: With `mode`=1 (bound), let S = max(1, NC/NT). Thread t is confined to the clusters starting at base (t*S) mod NC, and its target is base + (pointer mod S). The pointer advances after every four accepted instructions, as in R2.
- R4: Lanes are steered strictly in order. The first lane whose target cluster has no slot left stops the group. That slot count is the cluster's free count minus the earlier lanes of the same group sent there. `accept_cnt` equals the number of lanes before the stop. Lanes that are rejected or unused output cluster 0 and leave the thread state unchanged.
- R5: Only lanes below `in_count` are considered. An `in_count` above eight is treated as eight.
- R6: Within one group, no cluster receives more accepted lanes than its `cl_free` count.
- R7: On the cycle after `bc_start`, `bc_ready` has exactly the bit of `bc_cluster` set.
- R8: The remote clusters become ready exactly L cycles after the `bc_start` edge. L is `bc_lat`, where 0 is read as 1 and values above 8 are read as 8. A new `bc_start` restarts the timer.
- R9: `bc_done` is high exactly when every bit of `bc_ready` is set. Once set, readiness stays until the next `bc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 interleaved, 1 bound |
| in_count | input | 4 | Number of valid leading lanes |
| in_tid | input | 8 | Thread ID per lane, 1 bit each, lane 0 in the low bits |
| cl_free | input | 16 | Free slots per cluster, 4 bits each, cluster 0 in the low bits |
| lane_cluster | output | 16 | Target cluster per lane, 2 bits each |
| accept_cnt | output | 4 | Lanes accepted this cycle |
| bc_start | input | 1 | A value has been produced |
| bc_cluster | input | 2 | Producing cluster |
| bc_lat | input | 4 | Inter-cluster latency in cycles |
| bc_ready | output | 4 | Per-cluster readiness of the latest value |
| bc_done | output | 1 | Value visible in all clusters |

## Verification
The properties assume the following about the inputs:

- Thread IDs stay below the thread count.
- `cl_free` reflects real slot availability.
- At most one value is tracked at a time, because a new `bc_start` legitimately overrides the old one.

The stimulus uses two thread IDs on a one-bit field, so every ID is legal. It drives free counts from zero up to abundant. It varies `bc_lat` across the whole four-bit range, including the clamped values, and it fires `bc_start` both while the countdown is idle and while it is still running.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic {
        STEER_INTERLEAVE = 1'b0,
        STEER_BOUND      = 1'b1
    } steer_mode_e;

    localparam int RUN_LEN_DEF = 4;
endpackage

// File: rtl/steer_seq.sv
module steer_seq
    import steer_pkg::*;
#(
    parameter int NC     = 4,
    parameter int NT     = 2,
    parameter int W      = 8,
    parameter int RUN    = RUN_LEN_DEF,
    parameter int FREE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  steer_mode_e           mode,
    input  logic [$clog2(W+1)-1:0] in_count,
    input  logic [W*((NT>1)?$clog2(NT):1)-1:0] in_tid,
    input  logic [NC*FREE_W-1:0]  cl_free,
    output logic [W*$clog2(NC)-1:0] lane_cluster,
    output logic [$clog2(W+1)-1:0] accept_cnt
);
    localparam int CL_W  = $clog2(NC);
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1;
    localparam int CNT_W = $clog2(W + 1);
    localparam int RUN_W = (RUN > 1) ? $clog2(RUN) : 1;
    localparam int OWN_S = (NT >= NC) ? 1 : NC / NT;

    typedef struct packed {
        logic [NT-1:0][CL_W-1:0]  rot;
        logic [NT-1:0][RUN_W-1:0] run;
    } st_t;

    st_t st_q, st_d;

    logic [FREE_W-1:0] room [NC];
    logic [TID_W-1:0]  cur_tid;
    logic              stop;
    int                lim, acc, tgt;

    always_comb begin
        st_d         = st_q;
        lane_cluster = '0;
        stop         = 1'b0;
        acc          = 0;
        tgt          = 0;
        cur_tid      = '0;
        lim          = (int'(in_count) > W) ? W : int'(in_count);
        for (int c = 0; c < NC; c++) begin
            room[c] = cl_free[c*FREE_W +: FREE_W];
        end
        for (int i = 0; i < W; i++) begin
            cur_tid = in_tid[i*TID_W +: TID_W];
            if (i < lim && !stop) begin
                if (mode == STEER_INTERLEAVE) begin
                    tgt = int'(st_d.rot[cur_tid]);
                end else begin
                    tgt = ((int'(cur_tid) * OWN_S) % NC) + (int'(st_d.rot[cur_tid]) % OWN_S);
                end
                if (room[tgt] == '0) begin
                    stop = 1'b1;
                end else begin
                    lane_cluster[i*CL_W +: CL_W] = CL_W'(tgt);
                    room[tgt] = room[tgt] - 1'b1;
                    acc = acc + 1;
                    if (int'(st_d.run[cur_tid]) == RUN - 1) begin
                        st_d.run[cur_tid] = '0;
                        st_d.rot[cur_tid] = CL_W'((int'(st_d.rot[cur_tid]) + 1) % NC);
                    end else begin
                        st_d.run[cur_tid] = st_d.run[cur_tid] + 1'b1;
                    end
                end
            end
        end
        accept_cnt = CNT_W'(acc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    function automatic int hits(input logic [W*CL_W-1:0] lc, input logic [CNT_W-1:0] n, input int c);
        int k;
        k = 0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(n) && int'(lc[i*CL_W +: CL_W]) == c) k++;
        end
        return k;
    endfunction

    // R4: a group with nothing accepted leaves the rotation state untouched
    a_r4_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_cnt == '0) |=> (st_q == $past(st_q)));

    // R5: never more accepted than offered
    a_r5_accept_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(accept_cnt) <= int'(in_count)) && (int'(accept_cnt) <= W));

    for (genvar gc = 0; gc < NC; gc++) begin : g_room
        // R6: per-cluster placement within the advertised room
        a_r6_within_room: assert property (@(posedge clk) disable iff (!rst_n)
            hits(lane_cluster, accept_cnt, gc) <= int'(cl_free[gc*FREE_W +: FREE_W]));
    end

    for (genvar gl = 0; gl < W; gl++) begin : g_lane
        logic [TID_W-1:0] l_tid;
        assign l_tid = in_tid[gl*TID_W +: TID_W];
        // R3: bound mode keeps a thread inside its owned cluster subset
        a_r3_owned_set: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == STEER_BOUND && gl < int'(accept_cnt)) |->
            ((int'(lane_cluster[gl*CL_W +: CL_W]) - ((int'(l_tid) * OWN_S) % NC)) >= 0 &&
             (int'(lane_cluster[gl*CL_W +: CL_W]) - ((int'(l_tid) * OWN_S) % NC)) < OWN_S));
    end
endmodule

// File: rtl/bcast_timer.sv
module bcast_timer #(
    parameter int NC      = 4,
    parameter int LAT_W   = 4,
    parameter int LAT_MAX = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bc_start,
    input  logic [$clog2(NC)-1:0] bc_cluster,
    input  logic [LAT_W-1:0]      bc_lat,
    output logic [NC-1:0]         bc_ready,
    output logic                  bc_done
);
    typedef struct packed {
        logic [NC-1:0]    rdy;
        logic [LAT_W-1:0] cnt;
    } tm_t;

    tm_t tm_q, tm_d;
    logic [LAT_W-1:0] lat_c;

    always_comb begin
        if (bc_lat == '0)                  lat_c = LAT_W'(1);
        else if (int'(bc_lat) > LAT_MAX)   lat_c = LAT_W'(LAT_MAX);
        else                               lat_c = bc_lat;
        tm_d = tm_q;
        if (bc_start) begin
            tm_d.rdy = {{(NC-1){1'b0}}, 1'b1} << bc_cluster;
            tm_d.cnt = lat_c;
        end else if (tm_q.cnt != '0) begin
            tm_d.cnt = tm_q.cnt - 1'b1;
            if (tm_q.cnt == LAT_W'(1)) tm_d.rdy = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign bc_ready = tm_q.rdy;
    assign bc_done  = &tm_q.rdy;

    // R7: producing cluster sees the value on the next cycle
    a_r7_local_now: assert property (@(posedge clk) disable iff (!rst_n)
        bc_start |=> bc_ready[$past(bc_cluster)]);

    // R8: with latency above one, remotes are not yet ready right after start
    a_r8_remote_later: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_start && lat_c > LAT_W'(1)) |=> ($countones(bc_ready) == 1));

    // R9: full readiness persists until a new value starts
    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_done && !bc_start) |=> bc_done);
endmodule

// File: rtl/cluster_steer.sv
module cluster_steer
    import steer_pkg::*;
#(
    parameter int NC     = 4,
    parameter int NT     = 2,
    parameter int W      = 8,
    parameter int RUN    = RUN_LEN_DEF,
    parameter int FREE_W = 4,
    parameter int LAT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode,
    input  logic [$clog2(W+1)-1:0] in_count,
    input  logic [W*((NT>1)?$clog2(NT):1)-1:0] in_tid,
    input  logic [NC*FREE_W-1:0]  cl_free,
    output logic [W*$clog2(NC)-1:0] lane_cluster,
    output logic [$clog2(W+1)-1:0] accept_cnt,
    input  logic                  bc_start,
    input  logic [$clog2(NC)-1:0] bc_cluster,
    input  logic [LAT_W-1:0]      bc_lat,
    output logic [NC-1:0]         bc_ready,
    output logic                  bc_done
);
    steer_mode_e mode_e;
    assign mode_e = steer_mode_e'(mode);

    steer_seq #(.NC(NC), .NT(NT), .W(W), .RUN(RUN), .FREE_W(FREE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_e),
        .in_count     (in_count),
        .in_tid       (in_tid),
        .cl_free      (cl_free),
        .lane_cluster (lane_cluster),
        .accept_cnt   (accept_cnt)
    );

    bcast_timer #(.NC(NC), .LAT_W(LAT_W), .LAT_MAX(8)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bc_start   (bc_start),
        .bc_cluster (bc_cluster),
        .bc_lat     (bc_lat),
        .bc_ready   (bc_ready),
        .bc_done    (bc_done)
    );
endmodule

// File: tb/cluster_steer_tb.sv
module cluster_steer_tb;
    localparam int NC = 4, NT = 2, W = 8, FREE_W = 4, LAT_W = 4;
    localparam int S = (NT >= NC) ? 1 : NC / NT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [3:0]  in_count = '0;
    logic [7:0]  in_tid = '0;
    logic [15:0] cl_free = '0;
    logic [15:0] lane_cluster;
    logic [3:0]  accept_cnt;
    logic        bc_start = 1'b0;
    logic [1:0]  bc_cluster = '0;
    logic [3:0]  bc_lat = '0;
    logic [3:0]  bc_ready;
    logic        bc_done;

    cluster_steer u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_count(in_count), .in_tid(in_tid),
        .cl_free(cl_free), .lane_cluster(lane_cluster), .accept_cnt(accept_cnt),
        .bc_start(bc_start), .bc_cluster(bc_cluster), .bc_lat(bc_lat),
        .bc_ready(bc_ready), .bc_done(bc_done)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int m_rot[NT], m_run[NT];
    int m_rdy[NC];
    int m_cnt = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int md, input int cnt, input int tids[W], input int fr[NC],
                        input bit st, input int bcl, input int lat);
        int room[NC];
        int lim, acc, c, t, l;
        bit stop;
        int all;
        @(negedge clk);
        mode = md[0];
        in_count = 4'(cnt);
        for (int i = 0; i < W; i++) in_tid[i] = tids[i][0];
        for (int k = 0; k < NC; k++) cl_free[k*4 +: 4] = 4'(fr[k]);
        bc_start = st; bc_cluster = 2'(bcl); bc_lat = 4'(lat);
        #1;
        all = 1;
        for (int k = 0; k < NC; k++) begin
            chk("R8 bc_ready bit", int'(bc_ready[k]), m_rdy[k]);
            if (m_rdy[k] == 0) all = 0;
        end
        chk("R9 bc_done", int'(bc_done), all);
        lim = (cnt > W) ? W : cnt;
        acc = 0; stop = 0;
        for (int k = 0; k < NC; k++) room[k] = fr[k];
        for (int i = 0; i < W; i++) begin
            int exp;
            exp = 0;
            if (i < lim && !stop) begin
                t = tids[i];
                c = (md == 0) ? m_rot[t] : ((t * S) % NC) + (m_rot[t] % S);
                if (room[c] == 0) stop = 1;
                else begin
                    exp = c; room[c]--; acc++;
                    m_run[t]++;
                    if (m_run[t] == 4) begin m_run[t] = 0; m_rot[t] = (m_rot[t] + 1) % NC; end
                end
            end
            chk(md == 0 ? "R2 lane cluster" : "R3 lane cluster",
                int'(lane_cluster[i*2 +: 2]), exp);
        end
        chk("R4 accept_cnt", int'(accept_cnt), acc);
        if (st) begin
            for (int k = 0; k < NC; k++) m_rdy[k] = (k == bcl) ? 1 : 0;
            l = (lat == 0) ? 1 : (lat > 8 ? 8 : lat);
            m_cnt = l;
        end else if (m_cnt != 0) begin
            if (m_cnt == 1) for (int k = 0; k < NC; k++) m_rdy[k] = 1;
            m_cnt--;
        end
    endtask

    int tz[W] = '{default:0};
    int tmix[W] = '{0,1,0,0,1,1,0,1};
    int fbig[NC] = '{15,15,15,15};
    int fsmall[NC] = '{1,0,2,2};

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin m_rot[t] = 0; m_run[t] = 0; end
        for (int k = 0; k < NC; k++) m_rdy[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 bc_ready reset", int'(bc_ready), 0);
        chk("R1 bc_done reset", int'(bc_done), 0);
        rst_n = 1'b1;
        // R1, R2: first interleaved groups start at cluster 0 and rotate by runs of four
        step(0, 8, tz, fbig, 0, 0, 0);
        step(0, 8, tz, fbig, 0, 0, 0);
        step(0, 3, tmix, fbig, 0, 0, 0);
        // R5: empty group and oversize count
        step(0, 0, tmix, fbig, 0, 0, 0);
        step(0, 12, tmix, fbig, 0, 0, 0);
        // R3: bound mode
        step(1, 8, tmix, fbig, 0, 0, 0);
        step(1, 8, tz, fbig, 0, 0, 0);
        // R4, R6: scarce room stops the group
        step(0, 8, tz, fsmall, 0, 0, 0);
        step(1, 8, tmix, fsmall, 0, 0, 0);
        step(0, 8, tmix, '{0,0,0,0}, 0, 0, 0);
        // R7, R8, R9: timer with several latencies
        step(0, 0, tz, fbig, 1, 2, 3);
        repeat (5) step(0, 0, tz, fbig, 0, 0, 0);
        step(0, 0, tz, fbig, 1, 1, 0);
        repeat (3) step(0, 0, tz, fbig, 0, 0, 0);
        step(0, 0, tz, fbig, 1, 3, 12);
        repeat (4) step(0, 0, tz, fbig, 0, 0, 0);
        step(0, 0, tz, fbig, 1, 0, 5);
        repeat (10) step(0, 0, tz, fbig, 0, 0, 0);
        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int rt[W];
            int rf[NC];
            for (int i = 0; i < W; i++) rt[i] = $urandom_range(0, NT - 1);
            for (int k = 0; k < NC; k++) rf[k] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 15);
            step($urandom_range(0, 1), $urandom_range(0, 15), rt, rf,
                 ($urandom_range(0, 5) == 0), $urandom_range(0, NC - 1), $urandom_range(0, 15));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule